// File: doc/BRIEF.md
# Translation Buffer with Hardware Table Walk

This block turns 32-bit virtual addresses into 30-bit physical addresses for 4 KiB pages. It keeps a small fully associative set of recent translations. A request that matches a stored translation is answered in the same cycle. The upper 18 bits of the physical address come from the stored page number, and the low 12 bits are copied from the virtual address.

When no stored translation matches, the block fetches the page-table entry for the page from memory itself. The table is a single flat array whose start address comes from a base input. If the fetched entry is present, the block installs it and answers the retried request. If the entry is absent, the block reports a page fault. For each stored translation the block tracks whether the page was used and whether it was written. It writes these marks back to the table when it evicts the translation.

The requester holds its request, including the address and the base input, stable until `req_ready_o` rises. A single-word memory port serves both the table reads and the status write-backs.

Top module: `tlb_walker`

## Requirements
- R1: When a valid request matches a stored valid translation, `req_ready_o` and `resp_valid_o` are high in that same cycle. `resp_paddr_o` is then the stored 18-bit page number followed by virtual address bits 11..0, and no memory access is made.
- R2: A hit sets the used mark of the matching translation. A hit on a write request also sets its modified mark. Both marks become visible in the word written back when the translation is evicted.
- R3: On a miss `req_ready_o` stays low and the block reads the word at `ptbr_i + vpn*4`, where vpn is virtual address bits 31..12. In a table word, bit 31 is present, bit 30 is modified, bit 29 is used, and bits 17..0 are the physical page number.
- R4: If the fetched word has bit 31 set, it is installed with its own modified and used marks. In the cycle after the read is acknowledged, the held request is answered as a hit.
- R5: If the fetched word has bit 31 clear, then in the cycle after the read is acknowledged `fault_o` and `req_ready_o` are both high for exactly one cycle. `resp_valid_o` stays low and nothing is installed, so a later request to the same page walks the table again.
- R6: The slot chosen for a new translation is the lowest-numbered empty slot, if any slot is empty.
- R7: If no slot is empty, the chosen slot is the first one at or after the rotation pointer whose used mark is clear, searching upward with wrap-around. After each install the pointer moves to one past the slot just filled.
- R8: If no slot is empty and every used mark is set, all used marks are cleared when the miss begins, and the slot at the rotation pointer is chosen.
- R9: If the chosen slot holds a valid translation whose modified or used mark is set (marks taken before any clearing), the block first writes `{1, modified, used, 11 zero bits, page number}` to that translation's table address. The read for the new page follows only after this write.
- R10: A flush while no walk is active invalidates every translation from the next cycle on. In the flush cycle `req_ready_o` is low and no walk starts.
- R11: A flush while a walk is active, including the cycle that reports a fault, has no effect.
- R12: A memory request keeps `mem_req_o`, `mem_we_o` and `mem_addr_o` unchanged until `mem_ack_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Invalidate all translations |
| ptbr_i | input | 30 | Physical start address of the page table, word aligned |
| req_valid_i | input | 1 | Translation request present |
| req_ready_o | output | 1 | Request completes this cycle (hit or fault) |
| req_vaddr_i | input | 32 | Virtual address to translate |
| req_write_i | input | 1 | Request is a write access |
| resp_valid_o | output | 1 | Translation delivered this cycle |
| resp_paddr_o | output | 30 | Translated physical address |
| fault_o | output | 1 | Table entry absent, request completes with a fault |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory access is a write |
| mem_addr_o | output | 30 | Memory byte address |
| mem_wdata_o | output | 32 | Table word being written back |
| mem_ack_i | input | 1 | Memory access done; read data valid |
| mem_rdata_i | input | 32 | Table word read |

## Verification
The hardest situation to reach is an eviction in which every slot is valid and every used mark is set. This forces the mass clear, selection at the pointer, and a write-back of a word that carries the marks as they were before the clear. The stimulus gets there by filling all sixteen slots with retried requests, each of which marks its slot as used, and then requesting a seventeenth page. A long pseudo-random run over 48 pages, some of them absent, with varying memory latency and occasional flushes, then mixes partly cleared marks with rotating eviction. A behavioural model follows the buffer contents, the pointer and the walk, and checks every output on every cycle.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W      = 32;
  localparam int PA_W      = 30;
  localparam int OFF_W     = 12;
  localparam int VPN_W     = VA_W - OFF_W;
  localparam int PPN_W     = PA_W - OFF_W;
  localparam int PTE_W     = 32;
  localparam int PTE_V     = 31;
  localparam int PTE_D     = 30;
  localparam int PTE_R     = 29;
  localparam int PTE_PAD_W = PTE_W - 3 - PPN_W;

  typedef struct packed {
    logic             v;
    logic             d;
    logic             r;
    logic [VPN_W-1:0] tag;
    logic [PPN_W-1:0] ppn;
  } tlb_entry_t;

  typedef enum logic [1:0] {
    WS_IDLE  = 2'd0,
    WS_WB    = 2'd1,
    WS_RD    = 2'd2,
    WS_FAULT = 2'd3
  } walk_st_e;
endpackage

// File: rtl/tlb_lookup.sv
module tlb_lookup import tlb_pkg::*; #(
  parameter  int ENTRIES = 16,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  tlb_entry_t       ent_i [ENTRIES],
  input  logic [VPN_W-1:0] vpn_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [PPN_W-1:0] ppn_o
);
  logic [ENTRIES-1:0] match;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = ent_i[g].v && (ent_i[g].tag == vpn_i);
  end

  // at most one match: installs only happen on a miss
  always_comb begin
    idx_o = '0;
    ppn_o = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) begin
        idx_o = idx_o | IDX_W'(i);
        ppn_o = ppn_o | ent_i[i].ppn;
      end
    end
  end

  assign hit_o = |match;
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter  int ENTRIES = 16,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] v_i,
  input  logic [ENTRIES-1:0] r_i,
  input  logic [IDX_W-1:0]   ptr_i,
  output logic [IDX_W-1:0]   idx_o,
  output logic               clr_all_o
);
  logic found;
  int   j;

  always_comb begin
    found     = 1'b0;
    idx_o     = ptr_i;
    clr_all_o = 1'b0;
    j         = 0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!found && !v_i[i]) begin
        found = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
    if (!found) begin
      if (&r_i) begin
        clr_all_o = 1'b1;
        idx_o     = ptr_i;
      end else begin
        for (int k = 0; k < ENTRIES; k++) begin
          j = (int'(ptr_i) + k) % ENTRIES;
          if (!found && !r_i[j]) begin
            found = 1'b1;
            idx_o = IDX_W'(j);
          end
        end
      end
    end
  end
endmodule

// File: rtl/tlb_walk_ctrl.sv
module tlb_walk_ctrl import tlb_pkg::*; #(
  parameter  int ENTRIES = 16,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             miss_i,
  input  logic [VPN_W-1:0] vpn_i,
  input  logic [PA_W-1:0]  ptbr_i,
  input  logic [IDX_W-1:0] vict_idx_i,
  input  tlb_entry_t       vict_ent_i,
  input  logic             mem_ack_i,
  input  logic [PTE_W-1:0] mem_rdata_i,
  output walk_st_e         st_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [PA_W-1:0]  mem_addr_o,
  output logic [PTE_W-1:0] mem_wdata_o,
  output logic             install_o,
  output logic [IDX_W-1:0] install_idx_o,
  output tlb_entry_t       install_ent_o
);
  walk_st_e         st_q;
  logic [IDX_W-1:0] vict_q;
  logic [VPN_W-1:0] wb_tag_q;
  logic [PTE_W-1:0] wb_word_q;
  logic             pte_ok;
  logic             unused_pte_bits;

  assign pte_ok          = mem_rdata_i[PTE_V];
  assign unused_pte_bits = ^mem_rdata_i[PTE_W-4:PPN_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= WS_IDLE;
      vict_q    <= '0;
      wb_tag_q  <= '0;
      wb_word_q <= '0;
    end else begin
      unique case (st_q)
        WS_IDLE: if (miss_i) begin
          vict_q    <= vict_idx_i;
          wb_tag_q  <= vict_ent_i.tag;
          wb_word_q <= {1'b1, vict_ent_i.d, vict_ent_i.r, {PTE_PAD_W{1'b0}}, vict_ent_i.ppn};
          st_q      <= (vict_ent_i.v && (vict_ent_i.d || vict_ent_i.r)) ? WS_WB : WS_RD;
        end
        WS_WB:    if (mem_ack_i) st_q <= WS_RD;
        WS_RD:    if (mem_ack_i) st_q <= pte_ok ? WS_IDLE : WS_FAULT;
        WS_FAULT: st_q <= WS_IDLE;
        default:  st_q <= WS_IDLE;
      endcase
    end
  end

  assign st_o        = st_q;
  assign mem_req_o   = (st_q == WS_WB) || (st_q == WS_RD);
  assign mem_we_o    = (st_q == WS_WB);
  assign mem_addr_o  = (st_q == WS_WB) ? ptbr_i + PA_W'({wb_tag_q, 2'b00})
                                       : ptbr_i + PA_W'({vpn_i, 2'b00});
  assign mem_wdata_o = wb_word_q;

  assign install_o     = (st_q == WS_RD) && mem_ack_i && pte_ok;
  assign install_idx_o = vict_q;
  always_comb begin
    install_ent_o     = '0;
    install_ent_o.v   = 1'b1;
    install_ent_o.d   = mem_rdata_i[PTE_D];
    install_ent_o.r   = mem_rdata_i[PTE_R];
    install_ent_o.tag = vpn_i;
    install_ent_o.ppn = mem_rdata_i[PPN_W-1:0];
  end
endmodule

// File: rtl/tlb_walker.sv
module tlb_walker import tlb_pkg::*; #(
  parameter  int ENTRIES = 16,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic [PA_W-1:0]  ptbr_i,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [VA_W-1:0]  req_vaddr_i,
  input  logic             req_write_i,
  output logic             resp_valid_o,
  output logic [PA_W-1:0]  resp_paddr_o,
  output logic             fault_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [PA_W-1:0]  mem_addr_o,
  output logic [PTE_W-1:0] mem_wdata_o,
  input  logic             mem_ack_i,
  input  logic [PTE_W-1:0] mem_rdata_i
);
  tlb_entry_t         ent_q [ENTRIES];
  logic [IDX_W-1:0]   ptr_q;
  logic [ENTRIES-1:0] v_vec, r_vec;
  logic [VPN_W-1:0]   vpn;
  logic               hit;
  logic [IDX_W-1:0]   hit_idx;
  logic [PPN_W-1:0]   hit_ppn;
  logic [IDX_W-1:0]   vict_idx;
  logic               clr_all;
  walk_st_e           walk_st;
  logic               idle, miss, hit_fire;
  logic               install;
  logic [IDX_W-1:0]   install_idx;
  tlb_entry_t         install_ent;

  assign vpn = req_vaddr_i[VA_W-1:OFF_W];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_vec
    assign v_vec[g] = ent_q[g].v;
    assign r_vec[g] = ent_q[g].r;
  end

  tlb_lookup #(.ENTRIES(ENTRIES)) u_lookup (
    .ent_i (ent_q),
    .vpn_i (vpn),
    .hit_o (hit),
    .idx_o (hit_idx),
    .ppn_o (hit_ppn)
  );

  tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .v_i       (v_vec),
    .r_i       (r_vec),
    .ptr_i     (ptr_q),
    .idx_o     (vict_idx),
    .clr_all_o (clr_all)
  );

  tlb_walk_ctrl #(.ENTRIES(ENTRIES)) u_walk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .miss_i        (miss),
    .vpn_i         (vpn),
    .ptbr_i        (ptbr_i),
    .vict_idx_i    (vict_idx),
    .vict_ent_i    (ent_q[vict_idx]),
    .mem_ack_i     (mem_ack_i),
    .mem_rdata_i   (mem_rdata_i),
    .st_o          (walk_st),
    .mem_req_o     (mem_req_o),
    .mem_we_o      (mem_we_o),
    .mem_addr_o    (mem_addr_o),
    .mem_wdata_o   (mem_wdata_o),
    .install_o     (install),
    .install_idx_o (install_idx),
    .install_ent_o (install_ent)
  );

  assign idle     = (walk_st == WS_IDLE);
  assign hit_fire = req_valid_i && idle && hit && !flush_i;
  assign miss     = req_valid_i && idle && !hit && !flush_i;

  assign req_ready_o  = (idle && hit && !flush_i) || (walk_st == WS_FAULT);
  assign resp_valid_o = hit_fire;
  assign resp_paddr_o = {hit_ppn, req_vaddr_i[OFF_W-1:0]};
  assign fault_o      = (walk_st == WS_FAULT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) ent_q[i] <= '0;
      ptr_q <= '0;
    end else begin
      if (idle && flush_i) begin
        for (int i = 0; i < ENTRIES; i++) ent_q[i].v <= 1'b0;
      end else if (hit_fire) begin
        ent_q[hit_idx].r <= 1'b1;
        if (req_write_i) ent_q[hit_idx].d <= 1'b1;
      end else if (miss && clr_all) begin
        for (int i = 0; i < ENTRIES; i++) ent_q[i].r <= 1'b0;
      end
      if (install) begin
        ent_q[install_idx] <= install_ent;
        ptr_q <= (install_idx == IDX_W'(ENTRIES - 1)) ? '0 : install_idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tlb_walker_chk.sv
module tlb_walker_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        flush_i,
  input logic        req_valid_i,
  input logic        req_ready_o,
  input logic        resp_valid_o,
  input logic        fault_o,
  input logic        mem_req_o,
  input logic        mem_we_o,
  input logic [29:0] mem_addr_o,
  input logic        mem_ack_i,
  input logic        pte_present
);
  a_r1_hit_without_mem: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> (req_ready_o && !mem_req_o));

  a_r3_walk_holds_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !req_ready_o);

  a_r4_refill_then_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o && mem_ack_i && pte_present && req_valid_i)
      |=> (resp_valid_o || flush_i || !req_valid_i));

  a_r5_fault_after_absent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o && mem_ack_i && !pte_present)
      |=> (fault_o && req_ready_o && !resp_valid_o));

  a_r5_fault_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> !fault_o);

  a_r9_write_before_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && mem_ack_i) |=> (mem_req_o && !mem_we_o));

  a_r10_flush_no_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i && !mem_req_o && !fault_o) |-> !req_ready_o);

  a_r10_flush_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i && !mem_req_o && !fault_o) |=> !resp_valid_o);

  a_r12_mem_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_we_o) && $stable(mem_addr_o)));
endmodule

bind tlb_walker tlb_walker_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .flush_i      (flush_i),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .resp_valid_o (resp_valid_o),
  .fault_o      (fault_o),
  .mem_req_o    (mem_req_o),
  .mem_we_o     (mem_we_o),
  .mem_addr_o   (mem_addr_o),
  .mem_ack_i    (mem_ack_i),
  .pte_present  (mem_rdata_i[31])
);

// File: tb/tb_tlb_walker.sv
module tb_tlb_walker;
  localparam int N = 16;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        flush_i = 1'b0;
  logic [29:0] ptbr_i = 30'h0040_0000;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [31:0] req_vaddr_i = '0;
  logic        req_write_i = 1'b0;
  logic        resp_valid_o;
  logic [29:0] resp_paddr_o;
  logic        fault_o;
  logic        mem_req_o, mem_we_o;
  logic [29:0] mem_addr_o;
  logic [31:0] mem_wdata_o;
  logic        mem_ack_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;

  always #4 clk_i = ~clk_i;

  tlb_walker dut (.*);

  int checks = 0, fails = 0, cyc = 0;
  logic [31:0] pt [int];
  int mem_lat = 0, mem_cnt = 0;

  // model state
  bit          mv [N];
  logic [19:0] mtag [N];
  logic [17:0] mppn [N];
  bit          md [N], mr [N];
  int          mptr = 0, phase = 0, vict = 0;
  logic [29:0] wb_addr;
  logic [31:0] wb_data;

  function automatic logic [19:0] vpn_of(int i);
    return 20'(i * 32'h0001_3579 + 7);
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h t=%0t", req, what, act, exp, $time);
    end
  endtask

  // memory responder
  always @(negedge clk_i) begin
    if (mem_ack_i) begin
      mem_ack_i = 1'b0;
      mem_cnt = 0;
    end else if (rst_ni && mem_req_o) begin
      if (mem_cnt >= mem_lat) begin
        int idx;
        idx = int'(mem_addr_o >> 2);
        if (mem_we_o) pt[idx] = mem_wdata_o;
        mem_rdata_i = pt.exists(idx) ? pt[idx] : 32'h0;
        mem_ack_i = 1'b1;
      end else mem_cnt++;
    end
  end

  task automatic model_step();
    logic [19:0] vpn;
    bit hit, all_r, found;
    int hi;
    vpn = req_vaddr_i[31:12];
    hit = 0; hi = 0;
    for (int i = 0; i < N; i++) if (mv[i] && mtag[i] == vpn) begin hit = 1; hi = i; end
    case (phase)
      0: begin
        chk(flush_i ? "R10" : "R1", "ready", req_ready_o, 32'(hit && !flush_i));
        chk("R1", "resp_valid", resp_valid_o, 32'(req_valid_i && hit && !flush_i));
        chk("R5", "fault", fault_o, 0);
        chk("R12", "mem_req", mem_req_o, 0);
        if (req_valid_i && hit && !flush_i)
          chk("R1", "paddr", resp_paddr_o, {mppn[hi], req_vaddr_i[11:0]});
        if (flush_i) begin
          for (int i = 0; i < N; i++) mv[i] = 0;  // R10
        end else if (req_valid_i) begin
          if (hit) begin
            mr[hi] = 1;                          // R2
            if (req_write_i) md[hi] = 1;
          end else begin
            found = 0;
            for (int i = 0; i < N; i++) if (!found && !mv[i]) begin found = 1; vict = i; end  // R6
            if (!found) begin
              all_r = 1;
              for (int i = 0; i < N; i++) all_r &= mr[i];
              if (all_r) vict = mptr;            // R8, marks cleared below
              else for (int k = 0; k < N; k++)   // R7
                if (!found && !mr[(mptr + k) % N]) begin found = 1; vict = (mptr + k) % N; end
            end
            wb_addr = ptbr_i + 30'({mtag[vict], 2'b00});
            wb_data = {1'b1, md[vict], mr[vict], 11'h0, mppn[vict]};
            phase = (mv[vict] && (md[vict] || mr[vict])) ? 1 : 2;
            if (!found && all_r) for (int i = 0; i < N; i++) mr[i] = 0;
          end
        end
      end
      1: begin
        chk("R3", "ready", req_ready_o, 0);
        chk("R12", "mem_req", mem_req_o, 1);
        chk("R9", "mem_we", mem_we_o, 1);
        chk("R9", "wb_addr", mem_addr_o, wb_addr);
        chk("R2/R9", "wb_data", mem_wdata_o, wb_data);
        if (mem_ack_i) phase = 2;
      end
      2: begin
        chk("R3", "ready", req_ready_o, 0);
        chk("R12", "mem_req", mem_req_o, 1);
        chk("R9", "mem_we", mem_we_o, 0);
        chk("R3", "rd_addr", mem_addr_o, ptbr_i + 30'({vpn, 2'b00}));
        if (mem_ack_i) begin
          if (mem_rdata_i[31]) begin              // R4
            mv[vict] = 1; mtag[vict] = vpn; mppn[vict] = mem_rdata_i[17:0];
            md[vict] = mem_rdata_i[30]; mr[vict] = mem_rdata_i[29];
            mptr = (vict + 1) % N;
            phase = 0;
          end else phase = 3;
        end
      end
      default: begin
        chk("R5", "ready", req_ready_o, 1);
        chk("R5", "fault", fault_o, 1);
        chk("R5", "resp_valid", resp_valid_o, 0);
        phase = 0;                                 // R11: flush here ignored
      end
    endcase
  endtask

  always @(negedge clk_i) begin
    #3;
    if (rst_ni) model_step();
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic access(input int i, input bit we, input int flush_at,
                        output bit rv, output bit flt, output bit walked);
    bit done;
    @(negedge clk_i);
    req_valid_i = 1; req_write_i = we;
    req_vaddr_i = {vpn_of(i), 12'(i * 37)};
    rv = 0; flt = 0; walked = 0; done = 0;
    for (int c = 0; c < 5000; c++) begin
      #3;
      if (mem_req_o) walked = 1;
      done = req_ready_o; rv = resp_valid_o; flt = fault_o;
      @(negedge clk_i);
      flush_i = (c + 1 == flush_at);
      if (done) break;
    end
    req_valid_i = 0; flush_i = 0;
  endtask

  function automatic bit absent(int i);
    return (i % 7) == 5;
  endfunction

  initial begin
    bit rv, flt, wk;
    int seed;
    for (int i = 0; i < 48; i++)
      pt[int'((ptbr_i + 30'({vpn_of(i), 2'b00})) >> 2)] =
        {!absent(i), (i % 4) == 1, 1'b0, 11'h0, 18'(i * 165 + 3)};
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i); #3;
    chk("R1", "reset ready", req_ready_o, 0);
    chk("R12", "reset mem_req", mem_req_o, 0);
    chk("R5", "reset fault", fault_o, 0);

    // fill: empty slots first (R6), absent pages fault (R5), 17th page evicts (R8)
    for (int i = 0; i < 19; i++) begin
      mem_lat = i % 3;
      access(i, i % 3 == 0, -1, rv, flt, wk);
      chk(absent(i) ? "R5" : "R4", "fill result", {rv, flt}, absent(i) ? 2'b01 : 2'b10);
      chk("R3", "fill walked", wk, 1);
    end
    access(12, 0, -1, rv, flt, wk);
    chk("R5", "refault", {rv, flt, wk}, 3'b011);

    // hits and rotating replacement (R1 R2 R7)
    for (int i = 0; i < 24; i++) begin
      mem_lat = (i + 1) % 4;
      access(i, i % 2 == 1, -1, rv, flt, wk);
      chk(absent(i) ? "R5" : "R1", "second pass", rv, 32'(!absent(i)));
    end
    access(20, 0, -1, rv, flt, wk);
    chk("R1", "recent hit no walk", {rv, wk}, 2'b10);

    // flush during walk is ignored (R11)
    mem_lat = 3;
    access(30, 1, 2, rv, flt, wk);
    chk("R11", "walk with flush", {rv, wk}, 2'b11);
    access(20, 0, -1, rv, flt, wk);
    chk("R11", "kept after flush in walk", {rv, wk}, 2'b10);
    access(30, 0, -1, rv, flt, wk);
    chk("R11", "new entry kept", {rv, wk}, 2'b10);

    // flush while idle (R10)
    @(negedge clk_i); flush_i = 1;
    @(negedge clk_i); flush_i = 0;
    access(30, 0, -1, rv, flt, wk);
    chk("R10", "walk after flush", {rv, wk}, 2'b11);

    // random mix
    seed = 12345;
    for (int n = 0; n < 500; n++) begin
      int i;
      seed = seed * 1103515245 + 12345;
      i = ((seed >>> 8) & 32'h7fff_ffff) % 48;
      mem_lat = (seed >>> 20) & 3;
      if (((seed >>> 4) & 63) == 0) begin
        @(negedge clk_i); flush_i = 1;
        @(negedge clk_i); flush_i = 0;
      end
      access(i, ((seed >>> 12) & 1) == 1, ((seed >>> 14) & 7) == 0 ? 2 : -1, rv, flt, wk);
      chk(absent(i) ? "R5" : "R4", "random result", {rv, flt}, absent(i) ? 2'b01 : 2'b10);
    end

    repeat (4) @(negedge clk_i);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule